// File: doc/BRIEF.md
# SPI-Mode Serial Port Master

This block is a synchronous serial port that works as an SPI master. A host sets a clock divide value and a parallel transmit word, then pulses `start`. The port pulls its active-low slave select low and drives the first data bit. It then runs the serial clock for exactly one word, shifting data out most-significant bit first and sampling receive data on every rising clock edge. At the end it releases slave select and puts the data output into high impedance. The received word is presented together with a one-cycle `done` strobe.

The serial clock comes from a divider. Its input is either half the core clock or an external clock that is synchronised into the core domain. The divide value `div` gives a serial period of `div + 1` divider-input periods. How that period is split between the high and low phases depends on whether `div` is even or odd. Between frames the serial clock rests low and does not toggle. `clk_sel` must stay stable while a transfer runs.

Top module: `spim_master`

## Requirements
- R1: The serial clock period is `div + 1` divider-input periods. A divider-input period is 2 core cycles when `clk_sel` = 0, and one external clock period when `clk_sel` = 1.
- R2: For an even, non-zero `div`, each high phase lasts `div/2 + 1` input periods and each low phase lasts `div/2` input periods.
- R3: For an odd `div`, the high and low phases each last `(div + 1)/2` input periods.
- R4: With `div` = 0, the serial clock follows the divider input directly, so it is high while the input is high and low while it is low.
- R5: `clk_sel` = 0 selects half the core clock as the divider input. `clk_sel` = 1 selects the synchronised `ext_clk`.
- R6: `ss_n` is high after reset and between frames. It goes low at least one core cycle before the first rising edge of `sclk`.
- R7: `mosi_o` carries `tx_word` most-significant bit first. Bit WORD_W-1 is valid when `ss_n` falls, and each following bit appears at a falling edge of `sclk`.
- R8: `miso` is sampled on each of the WORD_W rising edges of `sclk`. The first sample lands in bit WORD_W-1 of `rx_word`.
- R9: `mosi_oe` is 1 exactly while `ss_n` is low. `mosi_o` is driven only during the frame and is released after the last falling edge.
- R10: `sclk` is low after reset and whenever `ss_n` is high. Each frame has exactly WORD_W rising edges.
- R11: `done` pulses high for one core cycle when `ss_n` rises, and `rx_word` holds the received word from that cycle on.
- R12: `busy` is 1 from the cycle after an accepted `start` until `ss_n` is released. A `start` seen while `busy` is 1 is ignored: it starts no new frame and does not change the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | Divider input select: 0 half core clock, 1 external clock |
| ext_clk | input | 1 | External divider input clock |
| div | input | DIV_W | Divide value, captured at start |
| start | input | 1 | Start request, one core cycle |
| tx_word | input | WORD_W | Word to transmit, captured at start |
| rx_word | output | WORD_W | Last received word |
| done | output | 1 | One-cycle strobe when rx_word is updated |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial transmit data |
| mosi_oe | output | 1 | Output enable for mosi_o (0 means high impedance) |
| miso | input | 1 | Serial receive data |

## Verification
The hardest conditions to create from the ports are the phase widths for the external clock source and for `div` = 0. In those cases the serial clock is only as wide as a synchronised external level or a single core cycle. The bench runs a free external clock with a six-cycle period. It measures every high and low run of `sclk` inside each frame and compares them with the parity rule for both sources and several divide values. A second `start` is pulsed in the middle of a frame with a different word, and the captured serial stream must still match the first word.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } spim_state_e;

    typedef enum logic [0:0] {
        SRC_HALF_CORE = 1'b0,
        SRC_EXTERNAL  = 1'b1
    } spim_src_e;

endpackage

// File: rtl/spim_srcclk.sv
module spim_srcclk
    import spim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic ext_clk,
    output logic src_rise,
    output logic src_fall
);

    typedef struct packed {
        logic half;
        logic sync1;
        logic sync2;
        logic prev;
    } src_regs_t;

    src_regs_t r_q, r_d;
    logic      level;

    always_comb begin
        r_d       = r_q;
        r_d.half  = ~r_q.half;
        r_d.sync1 = ext_clk;
        r_d.sync2 = r_q.sync1;
        level     = (spim_src_e'(sel) == SRC_EXTERNAL) ? r_q.sync2 : r_q.half;
        r_d.prev  = level;
        src_rise  = level & ~r_q.prev;
        src_fall  = ~level & r_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/spim_bitclk.sv
module spim_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             allow_rise,
    input  logic [DIV_W-1:0] div,
    input  logic             src_rise,
    input  logic             src_fall,
    output logic             sclk,
    output logic             rise_evt,
    output logic             fall_evt
);

    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic          sclk;
        logic          first;
        logic [CW-1:0] cnt;
    } bc_regs_t;

    bc_regs_t      r_q, r_d;
    logic [CW-1:0] div_ext;
    logic [CW-1:0] hi_len;
    logic [CW-1:0] lo_len;
    logic [CW-1:0] cnt_inc;
    logic          div_zero;

    always_comb begin
        div_ext  = {1'b0, div};
        div_zero = (div == '0);
        if (div_zero) begin
            hi_len = '0;
            lo_len = CW'(1);
        end else if (div[0]) begin
            hi_len = (div_ext + CW'(1)) >> 1;
            lo_len = (div_ext + CW'(1)) >> 1;
        end else begin
            hi_len = (div_ext >> 1) + CW'(1);
            lo_len = div_ext >> 1;
        end
    end

    always_comb begin
        r_d      = r_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        cnt_inc  = r_q.cnt + CW'(1);
        if (!run) begin
            r_d.sclk  = 1'b0;
            r_d.first = 1'b1;
            r_d.cnt   = '0;
        end else if (!r_q.sclk) begin
            if (src_rise && allow_rise) begin
                if (r_q.first || cnt_inc == lo_len) begin
                    rise_evt  = 1'b1;
                    r_d.sclk  = 1'b1;
                    r_d.first = 1'b0;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
        end else if (div_zero) begin
            if (src_fall) begin
                fall_evt = 1'b1;
                r_d.sclk = 1'b0;
                r_d.cnt  = '0;
            end
        end else if (src_rise) begin
            if (cnt_inc == hi_len) begin
                fall_evt = 1'b1;
                r_d.sclk = 1'b0;
                r_d.cnt  = '0;
            end else begin
                r_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sclk: 1'b0, first: 1'b1, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk = r_q.sclk;

    // R1: a serial clock rising edge only ever follows a divider-input rising edge
    a_r1_rise_on_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sclk) |-> $past(src_rise));

    // R10: with the frame released the clock stays low
    a_r10_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !r_q.sclk);

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [WORD_W-1:0] rx_bits
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_regs_t;

    sh_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.tx = load_word;
        end else if (shift) begin
            r_d.tx = {r_q.tx[WORD_W-2:0], 1'b0};
        end
        if (sample) begin
            r_d.rx = {r_q.rx[WORD_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mosi_bit = r_q.tx[WORD_W-1];
    assign rx_bits  = r_q.rx;

endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic              ext_clk,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              done,
    output logic              busy,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        spim_state_e       state;
        logic [CNT_W-1:0]  left;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] rx;
        logic              done;
    } ctl_regs_t;

    ctl_regs_t         r_q, r_d;
    logic              src_rise, src_fall;
    logic              rise_evt, fall_evt;
    logic              load, shift, run, allow_rise;
    logic              mosi_bit;
    logic [WORD_W-1:0] rx_bits;

    spim_srcclk u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (clk_sel),
        .ext_clk  (ext_clk),
        .src_rise (src_rise),
        .src_fall (src_fall)
    );

    spim_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .allow_rise (allow_rise),
        .div        (r_q.div),
        .src_rise   (src_rise),
        .src_fall   (src_fall),
        .sclk       (sclk),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt)
    );

    spim_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (tx_word),
        .shift     (shift),
        .sample    (rise_evt),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .rx_bits   (rx_bits)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        load       = 1'b0;
        run        = (r_q.state == ST_XFER);
        allow_rise = (r_q.left != '0);
        shift      = fall_evt && (r_q.left != '0);
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    load      = 1'b1;
                    r_d.state = ST_XFER;
                    r_d.left  = CNT_W'(WORD_W);
                    r_d.div   = div;
                end
            end
            default: begin
                if (rise_evt) begin
                    r_d.left = r_q.left - CNT_W'(1);
                end
                if (fall_evt && r_q.left == '0) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.rx    = rx_bits;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, left: '0, div: '0, rx: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.state == ST_XFER);
    assign ss_n    = (r_q.state == ST_IDLE);
    assign mosi_oe = (r_q.state == ST_XFER);
    assign mosi_o  = mosi_oe ? mosi_bit : 1'b0;
    assign done    = r_q.done;
    assign rx_word = r_q.rx;

    // R10: no clock activity outside a frame
    a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);

    // R6: the first rising clock edge comes after select has gone low
    a_r6_select_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(!ss_n));

    // R7: the most significant transmit bit is on the line when select falls
    a_r7_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> mosi_o == $past(tx_word[WORD_W-1]));

    // R11: completion strobe lasts a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: completion only ends a frame that was busy
    a_r12_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);

endmodule

// File: tb/spim_master_tb.sv
module spim_master_tb_top;

    localparam int W     = 16;
    localparam int DW    = 8;
    localparam int EHALF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_sel = 1'b0;
    logic          ext_clk = 1'b0;
    logic [DW-1:0] div = '0;
    logic          start = 1'b0;
    logic [W-1:0]  tx_word = '0;
    logic [W-1:0]  rx_word;
    logic          done, busy, sclk, ss_n, mosi_o, mosi_oe;
    logic          miso = 1'b0;

    spim_master #(.WORD_W(W), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
        .div(div), .start(start), .tx_word(tx_word), .rx_word(rx_word),
        .done(done), .busy(busy), .sclk(sclk), .ss_n(ss_n),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso(miso)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (EHALF) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    typedef struct {
        logic [W-1:0] tx;
        logic [W-1:0] srx;
        int           hi;
        int           lo;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   done_cnt = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor state
    logic         prev_sclk = 1'b0, prev_ss = 1'b1;
    logic [W-1:0] cap, slave_sr;
    int nrise, hi_run, lo_run, hi_meas, lo_meas, hi_bad, lo_bad, lead_bad, oe_bad, idle_bad;

    initial begin
        oe_bad = 0; idle_bad = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mosi_oe !== !ss_n) oe_bad++;
                if (ss_n && sclk) idle_bad++;
                if (prev_ss && !ss_n) begin
                    nrise = 0; hi_run = 0; lo_run = 0; hi_meas = -1; lo_meas = -1;
                    hi_bad = 0; lo_bad = 0; lead_bad = 0; cap = '0;
                    slave_sr = (q.size() > 0) ? q[0].srx : '0;
                    miso = slave_sr[W-1];
                end
                if (!prev_sclk && sclk) begin
                    if (prev_ss) lead_bad++;
                    if (nrise > 0) begin
                        if (lo_meas < 0) lo_meas = lo_run;
                        else if (lo_meas != lo_run) lo_bad++;
                    end
                    lo_run = 0;
                    nrise++;
                    cap = {cap[W-2:0], mosi_o};
                end
                if (prev_sclk && !sclk) begin
                    if (hi_meas < 0) hi_meas = hi_run;
                    else if (hi_meas != hi_run) hi_bad++;
                    hi_run = 0;
                    slave_sr = {slave_sr[W-2:0], 1'b0};
                    miso = slave_sr[W-1];
                end
                if (sclk) hi_run++;
                else if (nrise > 0 && !ss_n) lo_run++;
                if (done) begin
                    done_cnt++;
                    if (q.size() == 0) begin
                        chk(1'b0, "R12 unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(rx_word == e.srx, {"R8 R11 rx word ", e.tag}, rx_word, e.srx);
                        chk(cap == e.tx, {"R7 tx stream ", e.tag}, cap, e.tx);
                        chk(nrise == W, {"R10 edge count ", e.tag}, nrise, W);
                        chk(hi_meas == e.hi && hi_bad == 0, {"R1 R2 R3 R4 R5 high width ", e.tag}, hi_meas, e.hi);
                        chk(lo_meas == e.lo && lo_bad == 0, {"R1 R2 R3 R4 R5 low width ", e.tag}, lo_meas, e.lo);
                        chk(lead_bad == 0, {"R6 select lead ", e.tag}, lead_bad, 0);
                        chk(oe_bad == 0 && idle_bad == 0, {"R9 R10 enable and idle ", e.tag}, oe_bad, 0);
                        chk(!busy && ss_n, {"R12 busy released ", e.tag}, busy, 0);
                    end
                end
            end
            prev_sclk = sclk;
            prev_ss   = ss_n;
        end
    end

    function automatic void widths(input int g, input int per, output int hi, output int lo);
        if (g == 0) begin hi = per / 2; lo = per / 2; end
        else if (g % 2 == 1) begin hi = (g + 1) / 2 * per; lo = hi; end
        else begin hi = (g / 2 + 1) * per; lo = g / 2 * per; end
    endfunction

    task automatic push(input logic [W-1:0] tx, input logic [W-1:0] srx, input int g,
                        input logic sel, input string tag);
        exp_t e;
        e.tx = tx; e.srx = srx; e.tag = tag;
        widths(g, sel ? 2 * EHALF : 2, e.hi, e.lo);
        q.push_back(e);
    endtask

    task automatic xfer(input logic [W-1:0] tx, input logic [W-1:0] srx, input int g,
                        input logic sel, input string tag);
        int c0;
        @(negedge clk);
        clk_sel = sel; div = DW'(g); tx_word = tx;
        repeat (4) @(negedge clk);
        push(tx, srx, g, sel, tag);
        c0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !ss_n, {"R12 R6 busy after start ", tag}, busy, 1);
        wait (done_cnt == c0 + 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        chk(ss_n && !sclk && !mosi_oe && !busy && !done, "R6 R9 R10 reset state",
            {ss_n, sclk, mosi_oe, busy, done}, 5'b10000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ss_n && !sclk && !mosi_oe, "R10 idle after reset", {ss_n, sclk, mosi_oe}, 3'b100);

        xfer(16'hA5C3, 16'h3C5A, 0, 1'b0, "half div0 R4");
        xfer(16'hFFFF, 16'h0000, 1, 1'b0, "half div1 R3");
        xfer(16'h0000, 16'hFFFF, 2, 1'b0, "half div2 R2");
        xfer(16'h8001, 16'h8001, 3, 1'b0, "half div3 R3");
        xfer(16'h1234, 16'hFEDC, 4, 1'b0, "half div4 R2");
        xfer(16'h5A5A, 16'hC3C3, 5, 1'b0, "half div5 R1");
        xfer(16'h7E81, 16'h0F0F, 0, 1'b1, "ext div0 R5");
        xfer(16'hBEEF, 16'h1357, 3, 1'b1, "ext div3 R5");
        xfer(16'h0F1E, 16'hA0A0, 2, 1'b1, "ext div2 R5");

        // R12: a second start mid-frame is ignored
        @(negedge clk);
        clk_sel = 1'b0; div = DW'(2); tx_word = 16'hC0DE;
        repeat (4) @(negedge clk);
        push(16'hC0DE, 16'h6996, 2, 1'b0, "R12 ignored start");
        c0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        tx_word = 16'h1111;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R12 busy held across second start", busy, 1);
        wait (done_cnt == c0 + 1);
        repeat (60) @(negedge clk);
        chk(done_cnt == c0 + 1 && ss_n && !busy, "R12 no second frame", done_cnt - c0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule